// File: doc/BRIEF.md
# Rotating Serial Loop Store

This block is a bank of recirculating serial storage loops. Every loop is a closed shift path that holds a fixed number of words of fixed width, and one bit leaves the loop output on each clock before it re-enters at the far end. All loops turn in lockstep, so one shared bit counter and one shared word counter always say which bit of which word sits at the output of every loop. With the defaults a word is 32 bits and a loop holds 32 words, so one full turn takes 1024 clocks. A full-size bank would use 256 loops, giving a 13-bit address: 8 bits pick the loop and 5 bits pick the word.

A client presents one request at a time: a read or a write, a loop index and a word index. The block does not act at once. It waits until the addressed word starts to pass the loop output and then, for exactly one word period, either streams that word out serially, least significant bit first, or replaces it bit by bit with serial data from the client. The access time therefore depends on where the rotation stands when the request arrives, anywhere from 1 to a full turn of cycles. Every other word keeps recirculating untouched.

The controller has three states. IDLE holds while no request is open. A request in IDLE moves the controller to WAIT (accept-and-wait) or straight to XFER (accept-and-go) when the addressed word begins on the very next clock. WAIT moves to XFER (word-arrives) on the clock after the last bit of the word before the target. XFER returns to IDLE (word-done) after the last bit of the addressed word.

Top module: `circ_loop_mem`

## Requirements
- R1: After reset the bit counter starts at 0 and advances by one each clock, wrapping after WORD_BITS-1; the word counter starts at 0 and advances by one (wrapping after WORDS_PER_LOOP-1) each time the bit counter wraps. In the cycle where the counters read (w, b), every loop presents bit b of its word w at its output, so the rotation period is WORD_BITS*WORDS_PER_LOOP clocks.
- R2: Reset clears every stored bit to 0 and drives `busy`, `xfer_on` and `rd_data` low.
- R3: A request (`req_valid` high in a cycle where `busy` is low) is accepted at that clock edge. The transfer window opens in the first later cycle where the word counter equals `req_word` and the bit counter is 0. With p = counter position at acceptance (word*WORD_BITS+bit) and L the rotation period, the window opens k = ((req_word*WORD_BITS - p - 1) mod L) + 1 cycles after the acceptance cycle, so 1 <= k <= L.
- R4: `xfer_on` is high for exactly WORD_BITS consecutive cycles per request. `busy` is high from the cycle after acceptance through the last window cycle and low in the cycle after it.
- R5: On a write (`req_write` = 1), in the window cycle carrying bit b, the value on `wr_data` becomes bit b of the addressed word of the addressed loop; all other words and all other loops recirculate unchanged.
- R6: On a read (`req_write` = 0), `rd_data` carries bit b of the addressed word in window cycle b (bit 0 first); `rd_data` is 0 in every cycle outside a read window, and a read leaves the stored word unchanged.
- R7: `req_valid` while `busy` is high is ignored: the open request keeps its target and timing, and the ignored request changes no stored data.
- R8: Loops are independent stores: the same word index in two loops holds two separate values, selected by `req_loop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bit per loop moves per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while `busy` is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_loop | input | $clog2(NUM_LOOPS) | Loop index of the request |
| req_word | input | $clog2(WORDS_PER_LOOP) | Word index within the loop |
| wr_data | input | 1 | Serial write data, sampled in each write window cycle |
| busy | output | 1 | High while a request is waiting or transferring |
| xfer_on | output | 1 | High during the WORD_BITS cycles of the transfer window |
| rd_data | output | 1 | Serial read data, LSB first, 0 outside a read window |

## Verification
The two events that can meet in one cycle are the acceptance of a request and the start of its own transfer window: when the request arrives in the last bit of the word just before its target, the controller must go from IDLE directly to XFER. The bench waits for the counter position that sits one cycle before the target word and issues the request there, expecting a latency of exactly one cycle and correct data; it also issues a request exactly on the first bit of its own target word, where the window must not open until a full turn later. The same question arises when a new request lands in the very cycle `busy` falls, which every back-to-back access in the sweeps exercises, each judged by the latency formula of R3 against a counter position the bench keeps from reset.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_XFER = 2'd2
    } dlm_state_t;
endpackage

// File: rtl/dlm_timebase.sv
module dlm_timebase #(
    parameter int WORD_BITS      = 32,
    parameter int WORDS_PER_LOOP = 32,
    localparam int BIT_IDX_W     = $clog2(WORD_BITS),
    localparam int WORD_IDX_W    = $clog2(WORDS_PER_LOOP)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    output logic [BIT_IDX_W-1:0]  bit_idx,
    output logic [WORD_IDX_W-1:0] word_idx,
    output logic                  word_end,
    output logic [WORD_IDX_W-1:0] word_next
);
    localparam logic [BIT_IDX_W-1:0]  LAST_BIT  = BIT_IDX_W'(WORD_BITS - 1);
    localparam logic [WORD_IDX_W-1:0] LAST_WORD = WORD_IDX_W'(WORDS_PER_LOOP - 1);

    always_comb begin
        word_end  = (bit_idx == LAST_BIT);
        word_next = (word_idx == LAST_WORD) ? '0 : word_idx + WORD_IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx  <= '0;
            word_idx <= '0;
        end else if (word_end) begin
            bit_idx  <= '0;
            word_idx <= word_next;
        end else begin
            bit_idx  <= bit_idx + BIT_IDX_W'(1);
        end
    end

    AST_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx != LAST_BIT) |=> (bit_idx == $past(bit_idx) + BIT_IDX_W'(1)) && $stable(word_idx)); // R1
    AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx == LAST_BIT && word_idx != LAST_WORD) |=> (bit_idx == '0) && (word_idx == $past(word_idx) + WORD_IDX_W'(1))); // R1
    AST_TURN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_idx == LAST_BIT && word_idx == LAST_WORD) |=> (bit_idx == '0) && (word_idx == '0)); // R1
endmodule

// File: rtl/dlm_loop.sv
module dlm_loop #(
    parameter int LOOP_BITS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sub_en,
    input  logic sub_bit,
    output logic tap
);
    logic [LOOP_BITS-1:0] ring;
    logic                 feed;

    always_comb begin
        feed = sub_en ? sub_bit : ring[0];
        tap  = ring[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring <= '0;
        else        ring <= {feed, ring[LOOP_BITS-1:1]};
    end

    AST_RECIRC: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_en |=> (ring[LOOP_BITS-1] == $past(tap))); // R5
endmodule

// File: rtl/dlm_ctrl.sv
module dlm_ctrl
    import dlm_pkg::*;
#(
    parameter int WORD_BITS      = 32,
    parameter int WORDS_PER_LOOP = 32,
    parameter int NUM_LOOPS      = 2,
    localparam int BIT_IDX_W     = $clog2(WORD_BITS),
    localparam int WORD_IDX_W    = $clog2(WORDS_PER_LOOP),
    localparam int LOOP_IDX_W    = $clog2(NUM_LOOPS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [LOOP_IDX_W-1:0] req_loop,
    input  logic [WORD_IDX_W-1:0] req_word,
    input  logic [BIT_IDX_W-1:0]  bit_idx,
    input  logic [WORD_IDX_W-1:0] word_idx,
    input  logic                  word_end,
    input  logic [WORD_IDX_W-1:0] word_next,
    output logic                  busy,
    output logic                  xfer_on,
    output logic                  xfer_wr,
    output logic [LOOP_IDX_W-1:0] sel_loop
);
    dlm_state_t                state_q, state_d;
    logic [WORD_IDX_W-1:0]     tgt_word;
    logic [LOOP_IDX_W-1:0]     tgt_loop;
    logic                      tgt_write;
    logic                      take;

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    take    = 1'b1;
                    state_d = (word_end && word_next == req_word) ? ST_XFER : ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (word_end && word_next == tgt_word) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (word_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_word  <= '0;
            tgt_loop  <= '0;
            tgt_write <= 1'b0;
        end else if (take) begin
            tgt_word  <= req_word;
            tgt_loop  <= req_loop;
            tgt_write <= req_write;
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE);
        xfer_on  = (state_q == ST_XFER);
        xfer_wr  = tgt_write;
        sel_loop = tgt_loop;
    end

    AST_XFER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_on) |-> (bit_idx == '0) && (word_idx == tgt_word)); // R3
    AST_XFER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_on && word_end) |=> !xfer_on); // R4
    AST_XFER_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_on && !word_end) |=> xfer_on); // R4
    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(tgt_word) && $stable(tgt_loop) && $stable(tgt_write)); // R7
endmodule

// File: rtl/circ_loop_mem.sv
module circ_loop_mem #(
    parameter int NUM_LOOPS      = 2,
    parameter int WORD_BITS      = 32,
    parameter int WORDS_PER_LOOP = 32,
    localparam int LOOP_IDX_W    = $clog2(NUM_LOOPS),
    localparam int WORD_IDX_W    = $clog2(WORDS_PER_LOOP),
    localparam int BIT_IDX_W     = $clog2(WORD_BITS),
    localparam int LOOP_BITS     = WORD_BITS * WORDS_PER_LOOP
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [LOOP_IDX_W-1:0] req_loop,
    input  logic [WORD_IDX_W-1:0] req_word,
    input  logic                  wr_data,
    output logic                  busy,
    output logic                  xfer_on,
    output logic                  rd_data
);
    logic [BIT_IDX_W-1:0]  bit_idx;
    logic [WORD_IDX_W-1:0] word_idx;
    logic [WORD_IDX_W-1:0] word_next;
    logic                  word_end;
    logic                  xfer_wr;
    logic [LOOP_IDX_W-1:0] sel_loop;
    logic [NUM_LOOPS-1:0]  taps;
    logic [NUM_LOOPS-1:0]  sub_vec;

    dlm_timebase #(
        .WORD_BITS      (WORD_BITS),
        .WORDS_PER_LOOP (WORDS_PER_LOOP)
    ) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_idx   (bit_idx),
        .word_idx  (word_idx),
        .word_end  (word_end),
        .word_next (word_next)
    );

    dlm_ctrl #(
        .WORD_BITS      (WORD_BITS),
        .WORDS_PER_LOOP (WORDS_PER_LOOP),
        .NUM_LOOPS      (NUM_LOOPS)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_loop  (req_loop),
        .req_word  (req_word),
        .bit_idx   (bit_idx),
        .word_idx  (word_idx),
        .word_end  (word_end),
        .word_next (word_next),
        .busy      (busy),
        .xfer_on   (xfer_on),
        .xfer_wr   (xfer_wr),
        .sel_loop  (sel_loop)
    );

    for (genvar li = 0; li < NUM_LOOPS; li++) begin : g_loop
        assign sub_vec[li] = xfer_on && xfer_wr && (sel_loop == LOOP_IDX_W'(li));
        dlm_loop #(
            .LOOP_BITS (LOOP_BITS)
        ) u_loop (
            .clk     (clk),
            .rst_n   (rst_n),
            .sub_en  (sub_vec[li]),
            .sub_bit (wr_data),
            .tap     (taps[li])
        );
    end

    always_comb begin
        rd_data = (xfer_on && !xfer_wr) ? taps[sel_loop] : 1'b0;
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sub_vec)); // R5
    AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_vec != '0) |-> (xfer_on && busy)); // R5
endmodule

// File: tb/tb_circ_loop_mem.sv
module tb_circ_loop_mem;
    localparam int CLK_PERIOD = 10;
    localparam int NL  = 2;
    localparam int WB  = 32;
    localparam int WPL = 32;
    localparam int LB  = WB * WPL;
    localparam int LW  = $clog2(NL);
    localparam int WW  = $clog2(WPL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [LW-1:0] req_loop = '0;
    logic [WW-1:0] req_word = '0;
    logic          wr_data = 1'b0;
    logic          busy, xfer_on, rd_data;

    int checks = 0;
    int errors = 0;
    int pos = 0;
    int cyc = 0;
    logic [31:0] mem [NL][WPL];

    circ_loop_mem #(.NUM_LOOPS(NL), .WORD_BITS(WB), .WORDS_PER_LOOP(WPL)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_loop(req_loop), .req_word(req_word), .wr_data(wr_data),
        .busy(busy), .xfer_on(xfer_on), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // rotation position model, from R1
    always @(posedge clk) begin
        if (!rst_n) pos <= 0;
        else        pos <= (pos + 1) % LB;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
                summary();
                $finish;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int l, input int w);
        pat = {8'(l * 37 + 5), 8'(w * 11 + 3), 8'(w ^ 8'h5A), 8'(l + w * 3 + 1)};
    endfunction

    // Called at a negedge; returns at the negedge after the window.
    task automatic access(input int l, input int w, input bit wr, input logic [31:0] wdat,
                          input bit inject, input int il, input int iw,
                          output logic [31:0] rdat);
        int p, k;
        bit early, busy_bad, win_bad, rd_bad;
        p = pos;
        k = ((w * WB - p - 1 + 2 * LB) % LB) + 1;
        req_valid = 1'b1; req_write = wr; req_loop = LW'(l); req_word = WW'(w);
        early = 0; busy_bad = 0; win_bad = 0; rd_bad = 0; rdat = '0;
        for (int i = 1; i < k; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (inject && i == 2) begin
                req_valid = 1'b1; req_write = 1'b1; req_loop = LW'(il); req_word = WW'(iw);
                wr_data = 1'b1;
            end
            if (xfer_on) early = 1;
            if (!busy) busy_bad = 1;
            if (rd_data) rd_bad = 1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(!early && !busy_bad, "R3", "no window and busy before target word", {31'd0, early}, 32'd0);
        check(xfer_on === 1'b1, "R3", $sformatf("window opens after k=%0d cycles", k), {31'd0, xfer_on}, 32'd1);
        for (int b = 0; b < WB; b++) begin
            if (b > 0) @(negedge clk);
            if (!xfer_on || !busy) win_bad = 1;
            if (wr) begin
                wr_data = wdat[b];
                if (rd_data) rd_bad = 1;
            end else begin
                rdat[b] = rd_data;
            end
        end
        @(negedge clk);
        wr_data = 1'b0;
        check(!win_bad, "R4", "window held for WORD_BITS cycles", {31'd0, win_bad}, 32'd0);
        check(!busy && !xfer_on, "R4", "busy and window low after last bit", {30'd0, busy, xfer_on}, 32'd0);
        check(!rd_bad && !rd_data, "R6", "rd_data low outside read window", {31'd0, rd_bad}, 32'd0);
        if (wr) mem[l][w] = wdat;
        else check(rdat == mem[l][w], "R6", $sformatf("read loop %0d word %0d", l, w), rdat, mem[l][w]);
    endtask

    initial begin
        logic [31:0] r;
        for (int l = 0; l < NL; l++)
            for (int w = 0; w < WPL; w++) mem[l][w] = '0;

        repeat (3) @(negedge clk);
        check(!busy && !xfer_on && !rd_data, "R2", "outputs low in reset",
              {29'd0, busy, xfer_on, rd_data}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !xfer_on && !rd_data, "R2", "outputs low after reset",
              {29'd0, busy, xfer_on, rd_data}, 32'd0);

        // R2: cleared content
        access(0, 0, 1'b0, '0, 1'b0, 0, 0, r);
        access(NL - 1, WPL - 1, 1'b0, '0, 1'b0, 0, 0, r);

        // R5 R8: write every word of every loop
        for (int l = 0; l < NL; l++)
            for (int w = 0; w < WPL; w++)
                access(l, w, 1'b1, pat(l, w), 1'b0, 0, 0, r);
        // R6 R8: read everything back, reverse order
        for (int w = WPL - 1; w >= 0; w--)
            for (int l = 0; l < NL; l++)
                access(l, w, 1'b0, '0, 1'b0, 0, 0, r);

        // R3: request in last bit of word before target -> latency 1
        while (pos != (7 * WB - 1)) @(negedge clk);
        access(1, 7, 1'b0, '0, 1'b0, 0, 0, r);
        while (pos != (13 * WB - 1)) @(negedge clk);
        access(0, 13, 1'b1, 32'hC3A5_0F96, 1'b0, 0, 0, r);
        // R3: request on first bit of its own target -> full turn
        while (pos != 13 * WB) @(negedge clk);
        access(0, 13, 1'b0, '0, 1'b0, 0, 0, r);
        // R3: word 0 after wrap, requested at end of last word
        while (pos != LB - 1) @(negedge clk);
        access(1, 0, 1'b0, '0, 1'b0, 0, 0, r);

        // R5: overwrite one word, neighbours and other loop unchanged
        access(1, 5, 1'b1, 32'h8000_0001, 1'b0, 0, 0, r);
        access(1, 4, 1'b0, '0, 1'b0, 0, 0, r);
        access(1, 6, 1'b0, '0, 1'b0, 0, 0, r);
        access(0, 5, 1'b0, '0, 1'b0, 0, 0, r);
        access(1, 5, 1'b0, '0, 1'b0, 0, 0, r);
        // R6: repeated read does not disturb
        access(1, 5, 1'b0, '0, 1'b0, 0, 0, r);

        // R7: write request injected while busy is ignored
        while (pos != 20 * WB) @(negedge clk);
        access(0, 9, 1'b1, 32'h1234_ABCD, 1'b1, 1, 20, r);
        access(1, 20, 1'b0, '0, 1'b0, 0, 0, r);
        access(0, 9, 1'b0, '0, 1'b0, 0, 0, r);

        summary();
        $finish;
    end
endmodule